// File: doc/BRIEF.md
# Mode-configurable SPI slave

This block is the peripheral side of an SPI link, and it runs entirely on the local system clock. The serial clock, the active-low select and the MOSI line come in from the pins. Each passes through a two-flop synchronizer. The serial clock and the select then go through an edge detector. A 2-bit mode code chooses the idle level of the serial clock and the clock phase, so one netlist covers all four SPI modes.

When select falls, the block latches the mode code and a parallel transmit word from local logic. It then shifts that word out on MISO, most-significant bit first, and shifts MOSI bits into a receive register. When select rises, it raises a one-cycle done pulse. At the same time it presents the received word together with the number of bits clocked in that frame. MISO has an output-enable that is high only while the block is selected, so a pad cell can release the line when the block is not selected.

The system clock must run at least four times faster than the serial clock. Every pin event reaches the outputs three system clocks later.

Top module: `spi_mode_slave`

## Requirements
- R1: `mode_i` bit 1 selects the clock polarity and bit 0 selects the phase. With polarity 0 the leading edge of a bit cell is the rising edge of `sclk_i`; with polarity 1 it is the falling edge. The code is captured when select falls, and changes to `mode_i` during a frame have no effect on that frame.
- R2: With phase 0, `miso_oe_o` goes high and `miso_o` carries bit WORD_W-1 of the transmit word 3 system clocks after `ss_ni` falls, before any serial clock edge.
- R3: With phase 0, MOSI is sampled on each leading edge, and MISO moves to the next lower bit on each trailing edge.
- R4: With phase 1, each leading edge drives the next transmit bit, starting with the MSB, and MOSI is sampled on each trailing edge. After the last trailing edge, MISO keeps the last bit until select rises.
- R5: `miso_oe_o` is high only while a frame is active. After select rises, `miso_oe_o` and `miso_o` are both 0.
- R6: Each rise of select that ends a frame gives exactly one `done_o` pulse, one cycle long. In the same cycle `rx_word_o` takes the received bits, with the first bit received in the most significant used position and the last bit received at bit 0. Also in that cycle, `rx_count_o` takes the number of bits received. Both outputs hold until the next pulse.
- R7: The transmit word is taken from `tx_word_i` in the cycle the select fall is detected. Later changes to `tx_word_i` in the same frame do not alter the bits sent.
- R8: Serial clock and MOSI activity while select is high produce no done pulse, leave `miso_oe_o` and `miso_o` at 0, and leave `rx_word_o` and `rx_count_o` unchanged.
- R9: When a frame has more than WORD_W bits, `rx_count_o` saturates at WORD_W and `rx_word_o` holds the last WORD_W bits received. MISO sends 0 for every bit after the transmit word runs out.
- R10: After reset, `miso_o`, `miso_oe_o`, `done_o`, `rx_word_o` and `rx_count_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Mode code: bit 1 polarity, bit 0 phase |
| sclk_i | input | 1 | Serial clock from the bus controller |
| ss_ni | input | 1 | Select, active low |
| mosi_i | input | 1 | Serial data in |
| tx_word_i | input | WORD_W | Word to transmit, captured when select falls |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output-enable for the MISO pad |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| rx_word_o | output | WORD_W | Received word, right-aligned |
| rx_count_o | output | $clog2(WORD_W+1) | Bits received in the last frame, saturating |

## Verification
Each pin change takes two synchronizer flops and one state register to reach the outputs, so every result is due three system clocks after the pin change. This holds for the first MISO bit after the select fall, for each MISO update after a driving edge, and for the done pulse after the select rise. The bench changes pins on falling system-clock edges and keeps every serial half-period at six system clocks. It samples MISO just before it moves the serial clock, so each bit has had at least three clocks to settle. It reads the frame results eight clocks after raising select, and a counter driven on falling edges counts the done pulses between frames.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;

    // Packed so that a cast from the 2-bit code puts polarity in bit 1.
    typedef struct packed {
        logic pol;
        logic pha;
    } spi_mode_t;

    // Leading edge of a bit cell for the given idle polarity.
    function automatic logic pick_lead(input logic pol, input logic rise, input logic fall);
        return pol ? fall : rise;
    endfunction

    function automatic logic pick_trail(input logic pol, input logic rise, input logic fall);
        return pol ? rise : fall;
    endfunction

endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
module spi_slv_sync #(
    parameter int unsigned   LANES   = 3,
    parameter int unsigned   STAGES  = 2,
    parameter logic [LANES-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LANES-1:0] async_i,
    output logic [LANES-1:0] sync_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                pipe_q <= {STAGES{RST_VAL[g]}};
            end else begin
                pipe_q <= pipe_d;
            end
        end

        assign sync_o[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/spi_slv_edge.sv
`timescale 1ns/1ps
module spi_slv_edge
    import spi_slv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_s_i,
    input  logic ss_s_i,
    input  logic pol_i,
    output logic sel_fall_o,
    output logic sel_rise_o,
    output logic lead_o,
    output logic trail_o
);

    typedef struct packed {
        logic sclk;
        logic ss;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  sclk_rise, sclk_fall;

    always_comb begin
        hist_d.sclk = sclk_s_i;
        hist_d.ss   = ss_s_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q.sclk <= 1'b0;
            hist_q.ss   <= 1'b1;
        end else begin
            hist_q <= hist_d;
        end
    end

    always_comb begin
        sclk_rise  = sclk_s_i & ~hist_q.sclk;
        sclk_fall  = ~sclk_s_i & hist_q.sclk;
        sel_fall_o = ~ss_s_i & hist_q.ss;
        sel_rise_o = ss_s_i & ~hist_q.ss;
        lead_o     = pick_lead(pol_i, sclk_rise, sclk_fall);
        trail_o    = pick_trail(pol_i, sclk_rise, sclk_fall);
    end

endmodule

// File: rtl/spi_slv_core.sv
`timescale 1ns/1ps
module spi_slv_core
    import spi_slv_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        mode_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              sel_fall_i,
    input  logic              sel_rise_i,
    input  logic              lead_i,
    input  logic              trail_i,
    input  logic              mosi_s_i,
    output logic              pol_o,
    output logic              active_o,
    output logic              miso_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic [CNT_W-1:0]  rx_count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    typedef struct packed {
        logic              act;
        spi_mode_t         mode;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [CNT_W-1:0]  cnt;
        logic              miso;
        logic              done;
        logic [WORD_W-1:0] rx_word;
        logic [CNT_W-1:0]  rx_cnt;
    } core_t;

    core_t st_d, st_q;
    logic  do_sample, do_drive;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        do_sample = st_q.mode.pha ? trail_i : lead_i;
        do_drive  = st_q.mode.pha ? lead_i  : trail_i;

        if (sel_fall_i) begin
            st_d.act   = 1'b1;
            st_d.mode  = spi_mode_t'(mode_i);
            st_d.rx_sh = '0;
            st_d.cnt   = '0;
            if (mode_i[0]) begin
                // Phase 1: first bit goes out on the first leading edge.
                st_d.tx_sh = tx_word_i;
                st_d.miso  = 1'b0;
            end else begin
                // Phase 0: MSB is on the line before any clock edge.
                st_d.tx_sh = tx_word_i << 1;
                st_d.miso  = tx_word_i[WORD_W-1];
            end
        end else if (sel_rise_i) begin
            if (st_q.act) begin
                st_d.act     = 1'b0;
                st_d.done    = 1'b1;
                st_d.rx_word = st_q.rx_sh;
                st_d.rx_cnt  = st_q.cnt;
            end
            st_d.miso = 1'b0;
        end else if (st_q.act) begin
            if (do_sample) begin
                st_d.rx_sh = WORD_W'({st_q.rx_sh, mosi_s_i});
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (do_drive) begin
                st_d.miso  = st_q.tx_sh[WORD_W-1];
                st_d.tx_sh = st_q.tx_sh << 1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol_o      = st_q.mode.pol;
    assign active_o   = st_q.act;
    assign miso_o     = st_q.miso;
    assign done_o     = st_q.done;
    assign rx_word_o  = st_q.rx_word;
    assign rx_count_o = st_q.rx_cnt;

endmodule

// File: rtl/spi_mode_slave.sv
`timescale 1ns/1ps
module spi_mode_slave #(
    parameter int unsigned WORD_W    = 8,
    parameter int unsigned SYNC_FLOPS = 2
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [1:0]                    mode_i,
    input  logic                          sclk_i,
    input  logic                          ss_ni,
    input  logic                          mosi_i,
    input  logic [WORD_W-1:0]             tx_word_i,
    output logic                          miso_o,
    output logic                          miso_oe_o,
    output logic                          done_o,
    output logic [WORD_W-1:0]             rx_word_o,
    output logic [$clog2(WORD_W+1)-1:0]   rx_count_o
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam int unsigned LANES = 3;
    localparam int unsigned L_SCLK = 0;
    localparam int unsigned L_SS   = 1;
    localparam int unsigned L_MOSI = 2;

    logic [LANES-1:0] pins_raw, pins_s;
    logic sel_fall, sel_rise, lead, trail, pol, active;

    assign pins_raw[L_SCLK] = sclk_i;
    assign pins_raw[L_SS]   = ss_ni;
    assign pins_raw[L_MOSI] = mosi_i;

    spi_slv_sync #(
        .LANES  (LANES),
        .STAGES (SYNC_FLOPS),
        .RST_VAL(LANES'(1) << L_SS)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(pins_raw),
        .sync_o (pins_s)
    );

    spi_slv_edge i_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sclk_s_i  (pins_s[L_SCLK]),
        .ss_s_i    (pins_s[L_SS]),
        .pol_i     (pol),
        .sel_fall_o(sel_fall),
        .sel_rise_o(sel_rise),
        .lead_o    (lead),
        .trail_o   (trail)
    );

    spi_slv_core #(
        .WORD_W(WORD_W),
        .CNT_W (CNT_W)
    ) i_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode_i),
        .tx_word_i (tx_word_i),
        .sel_fall_i(sel_fall),
        .sel_rise_i(sel_rise),
        .lead_i    (lead),
        .trail_i   (trail),
        .mosi_s_i  (pins_s[L_MOSI]),
        .pol_o     (pol),
        .active_o  (active),
        .miso_o    (miso_o),
        .done_o    (done_o),
        .rx_word_o (rx_word_o),
        .rx_count_o(rx_count_o)
    );

    assign miso_oe_o = active;

endmodule

// File: rtl/spi_mode_slave_chk.sv
`timescale 1ns/1ps
module spi_mode_slave_chk #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [1:0]        mode_i,
    input logic [WORD_W-1:0] tx_word_i,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  rx_count_o,
    input logic              sel_fall_i,
    input logic              sel_rise_i,
    input logic              act_i
);

    a_r2_first_bit_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_fall_i && !mode_i[0]) |=> (miso_oe_o && (miso_o == $past(tx_word_i[WORD_W-1]))));

    a_r5_release_on_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_rise_i |=> !miso_oe_o);

    a_r5_quiet_when_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !miso_oe_o |-> !miso_o);

    a_r6_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r6_done_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_rise_i && act_i) |=> done_o);

    a_r6_count_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |=> (done_o || $stable(rx_count_o)));

    a_r9_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_count_o <= CNT_W'(WORD_W));

endmodule

bind spi_mode_slave spi_mode_slave_chk #(
    .WORD_W(WORD_W),
    .CNT_W ($clog2(WORD_W + 1))
) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .tx_word_i (tx_word_i),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o),
    .done_o    (done_o),
    .rx_count_o(rx_count_o),
    .sel_fall_i(sel_fall),
    .sel_rise_i(sel_rise),
    .act_i     (active)
);

// File: tb/test_spi_mode_slave.sv
`timescale 1ns/1ps
module test_spi_mode_slave;

    localparam int W = 8;
    localparam int H = 6;   // serial half-period in system clocks

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic         sclk_i = 1'b0;
    logic         ss_ni = 1'b1;
    logic         mosi_i = 1'b0;
    logic [W-1:0] tx_word_i = '0;
    logic         miso_o, miso_oe_o, done_o;
    logic [W-1:0] rx_word_o;
    logic [3:0]   rx_count_o;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_mode_slave #(.WORD_W(W)) i_spi_mode_slave (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .mode_i    (mode_i),
        .sclk_i    (sclk_i),
        .ss_ni     (ss_ni),
        .mosi_i    (mosi_i),
        .tx_word_i (tx_word_i),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe_o),
        .done_o    (done_o),
        .rx_word_o (rx_word_o),
        .rx_count_o(rx_count_o)
    );

    always @(negedge clk) if (rst_n && done_o) done_cnt++;

    typedef struct packed {
        logic [1:0]  mode;
        logic [4:0]  nbits;
        logic [7:0]  tx;
        logic [15:0] mosi;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{2'd0, 5'd8, 8'hA5, 16'h003C},
        '{2'd1, 5'd8, 8'h96, 16'h00C3},
        '{2'd2, 5'd8, 8'h5A, 16'h0081},
        '{2'd3, 5'd8, 8'hE1, 16'h007E},
        '{2'd0, 5'd5, 8'hC8, 16'h0013},
        '{2'd3, 5'd3, 8'h60, 16'h0005},
        '{2'd1, 5'd1, 8'h80, 16'h0001},
        '{2'd2, 5'd8, 8'h0F, 16'h00F0}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // One frame as bus controller. Tx word and mode are scrambled after capture (R7, R1).
    task automatic xfer(input logic [1:0] md, input int nb, input logic [7:0] tx,
                        input logic [15:0] mo, output logic [15:0] got);
        logic cpol, cpha;
        cpol = md[1];
        cpha = md[0];
        got = '0;
        sclk_i = cpol;
        mode_i = md;
        tx_word_i = tx;
        cyc(4);
        ss_ni = 1'b0;
        if (!cpha) mosi_i = mo[nb-1];
        cyc(4);
        if (!cpha) check("R2 first bit before clock", {30'd0, miso_oe_o, miso_o}, {30'd0, 1'b1, tx[7]});
        tx_word_i = ~tx;
        mode_i = ~md;
        cyc(H - 4);
        for (int i = 0; i < nb; i++) begin
            if (cpha) begin
                sclk_i = ~cpol;
                mosi_i = mo[nb-1-i];
                cyc(H);
                got = {got[14:0], miso_o};
                sclk_i = cpol;
                cyc(H);
            end else begin
                got = {got[14:0], miso_o};
                sclk_i = ~cpol;
                cyc(H);
                sclk_i = cpol;
                if (i < nb - 1) mosi_i = mo[nb-2-i];
                cyc(H);
            end
        end
        if (cpha && nb <= W) begin
            cyc(10);
            check("R4 last bit held", {31'd0, miso_o}, {31'd0, tx[W-nb]});
        end
        ss_ni = 1'b1;
        cyc(8);
    endtask

    initial begin
        logic [15:0] got;
        int d0;
        logic [7:0] exp_rx, saved_rx;
        logic [3:0] saved_cnt;

        cyc(5);
        check("R10 reset miso", {31'd0, miso_o}, 0);
        check("R10 reset oe", {31'd0, miso_oe_o}, 0);
        check("R10 reset done", {31'd0, done_o}, 0);
        check("R10 reset rx_word", {24'd0, rx_word_o}, 0);
        check("R10 reset rx_count", {28'd0, rx_count_o}, 0);
        rst_n = 1'b1;
        cyc(5);

        for (int v = 0; v < 8; v++) begin
            d0 = done_cnt;
            xfer(VECS[v].mode, int'(VECS[v].nbits), VECS[v].tx, VECS[v].mosi, got);
            exp_rx = 8'(VECS[v].mosi & ((16'd1 << VECS[v].nbits) - 16'd1));
            check("R6 one done pulse", done_cnt - d0, 1);
            check("R6/R1 rx_word", {24'd0, rx_word_o}, {24'd0, exp_rx});
            check("R6 rx_count", {28'd0, rx_count_o}, {27'd0, VECS[v].nbits});
            if (VECS[v].mode[0])
                check("R4/R7 miso stream", {16'd0, got}, {24'd0, VECS[v].tx} >> (W - VECS[v].nbits));
            else
                check("R3/R7 miso stream", {16'd0, got}, {24'd0, VECS[v].tx} >> (W - VECS[v].nbits));
            check("R5 released after frame", {30'd0, miso_oe_o, miso_o}, 0);
        end

        // R8: clock and data toggling while deselected
        saved_rx = rx_word_o;
        saved_cnt = rx_count_o;
        d0 = done_cnt;
        mode_i = 2'd0;
        for (int i = 0; i < 8; i++) begin
            sclk_i = ~sclk_i;
            mosi_i = ~mosi_i;
            cyc(H);
            if (miso_oe_o || miso_o) check("R8 outputs quiet", {30'd0, miso_oe_o, miso_o}, 0);
        end
        sclk_i = 1'b0;
        cyc(8);
        check("R8 no done", done_cnt - d0, 0);
        check("R8 oe low", {31'd0, miso_oe_o}, 0);
        check("R8 rx_word kept", {24'd0, rx_word_o}, {24'd0, saved_rx});
        check("R8 rx_count kept", {28'd0, rx_count_o}, {28'd0, saved_cnt});

        // R9: ten-bit frame on an eight-bit word
        d0 = done_cnt;
        xfer(2'd0, 10, 8'hB7, 16'h02D9, got);
        check("R9 done", done_cnt - d0, 1);
        check("R9 count saturates", {28'd0, rx_count_o}, 8);
        check("R9 last bits kept", {24'd0, rx_word_o}, 32'hD9);
        check("R9 zeros after word", {16'd0, got & 16'h03FF}, {22'd0, 8'hB7, 2'b00});

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule